// File: doc/BRIEF.md
# Multicore Shared-Interrupt Router

This block is the shared half of a multicore interrupt controller. It receives a set of level-sensitive common peripheral interrupt lines and steers each one to exactly one core. A line is never broadcast and never goes to a set of cores. Each line owns a steering register that holds a route-enable bit and a target core number. A global enable bit gates all delivery. Software reaches the registers through a plain word write port and a combinational read port inside a 32 KiB global window. Common interrupt line `i` carries interrupt ID `32 + i`. IDs below 32 (software-generated and per-core private) are not handled here.

Each line runs a small state machine with three states: `LN_IDLE`, `LN_PEND` and `LN_TAKEN`.
- **IDLE→PEND** (*capture*): the line is high, global delivery is on, and the line's route is valid. The target core is latched at this point.
- **PEND→TAKEN** (*accept*): the latched target core accepts the line while global delivery is on.
- **TAKEN→IDLE** (*release*): the line goes low.

In all other cases the state holds. A line in `LN_PEND` is shown on the pending vector of its latched core only.

The default configuration has 4 cores and 224 common lines, which gives interrupt IDs up to 255. The architecture allows up to 992 common lines. Per-core prioritisation and completion handling belong to the per-core interfaces, which present an accept strobe and a line index back to this block.

Top module: `irq_dist_top`

## Requirements
- R1: After reset every pending output is 0, and the control register and all steering registers read 0.
- R2: The control register sits at byte offset 0x0, and its bit 0 is the global delivery enable. The other bits read 0. While bit 0 is 0, no line is shown pending at any core.
- R3: The steering register of line i (interrupt ID 32+i) sits at byte offset 0x1000 + 4·i. Bit 31 is the route enable, and bits [TGT_W-1:0] hold the target core, where TGT_W = clog2(NUM_CORES). All other bits read 0. Offsets that are misaligned, past the last line, or otherwise unmapped (including 0x100) read 0, and writes to them change nothing.
- R4: When a line is high, delivery is enabled and its route is valid, the line appears on pend_o bit c·NUM_LINES + i of its target core c only. It appears right after the clock edge that samples it.
- R5: A line whose route enable is 0, or whose target number is NUM_CORES or higher, is shown at no core.
- R6: A pending line stays pending after its input falls. It is cleared only when its target core accepts it.
- R7: An accept from a core that is not the line's target, or one that names a different line, leaves the pending line unchanged.
- R8: After it is accepted, a line is not shown pending again until its input has been low for at least one clock edge and then rises again.
- R9: The target is latched at capture. Rewriting the steering register while the line is pending does not move it.
- R10: Clearing the global enable hides pending lines without discarding them, and accepts are ignored while it is clear. Setting the enable again shows them again at their original target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 15 | Byte offset in the global window, shared by reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_i | input | NUM_LINES | Level-sensitive common interrupt lines |
| acc_valid_i | input | NUM_CORES | Per-core accept strobe |
| acc_line_i | input | NUM_CORES·LINE_W | Per-core accepted line index; core c uses bits [c·LINE_W +: LINE_W] |
| pend_o | output | NUM_CORES·NUM_LINES | Pending lines; bit c·NUM_LINES+i is line i at core c |

## Verification
A line state machine stuck in the wrong state, or a wrong latched target, shows up on pend_o no later than the edge after the next input change: as a bit at the wrong core, a bit that clears before an accept, or a bit that reappears while the line is still held high. The bench uses 3 cores and 6 lines, so that target value 3 can be encoded but is out of range. It sweeps every line against every target value with the route enable both set and clear, then steps through accept, release, retarget and enable-masking sequences. A wrong steering register decode shows up at once on the read port, or as delivery to the wrong core one edge after the line rises.

// File: rtl/irq_dist_pkg.sv
`timescale 1ns/1ps
package irq_dist_pkg;

    // Global window and register placement (byte offsets)
    localparam int GLOBAL_WIN   = 'h8000;
    localparam int CTRL_OFS     = 'h0;
    localparam int STEER_BASE   = 'h1000;
    localparam int STEER_STRIDE = 4;
    localparam int STEER_EN_BIT = 31;
    localparam int FIRST_CMN_ID = 32;
    localparam int MAX_CMN      = 992;
    localparam int WIN_AW       = $clog2(GLOBAL_WIN);

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_PEND  = 2'd1,
        LN_TAKEN = 2'd2
    } line_state_t;

endpackage

// File: rtl/irq_dist_regs.sv
`timescale 1ns/1ps
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 224,
    parameter int TGT_W     = 2,
    parameter int ADDR_W    = WIN_AW
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             reg_wr_i,
    input  logic [ADDR_W-1:0]                reg_addr_i,
    input  logic [31:0]                      reg_wdata_i,
    output logic [31:0]                      reg_rdata_o,
    output logic                             gen_o,
    output logic [NUM_LINES-1:0]             steer_en_o,
    output logic [NUM_LINES-1:0][TGT_W-1:0]  steer_tgt_o
);

    localparam logic [ADDR_W-1:0] STEER_LO   = ADDR_W'(STEER_BASE);
    localparam logic [ADDR_W-1:0] STEER_SPAN = ADDR_W'(STEER_STRIDE * NUM_LINES);

    logic                             gen_q;
    logic [NUM_LINES-1:0]             en_q;
    logic [NUM_LINES-1:0][TGT_W-1:0]  tgt_q;

    logic                             aligned;
    logic                             ctrl_hit;
    logic                             steer_hit;
    logic [ADDR_W-1:0]                steer_off;
    logic [ADDR_W-1:0]                steer_word;
    logic                             unused_wbits;

    assign unused_wbits = ^reg_wdata_i[30:TGT_W];

    // Address decode
    always_comb begin
        aligned    = (reg_addr_i[1:0] == 2'b00);
        ctrl_hit   = (reg_addr_i == ADDR_W'(CTRL_OFS));
        steer_off  = reg_addr_i - STEER_LO;
        steer_word = steer_off >> 2;
        steer_hit  = aligned && (reg_addr_i >= STEER_LO) && (steer_off < STEER_SPAN);
    end

    // Global control register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gen_q <= 1'b0;
        end else if (reg_wr_i && ctrl_hit) begin
            gen_q <= reg_wdata_i[0];
        end
    end

    // Steering registers, one per common line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_steer
        logic sel;
        assign sel = reg_wr_i && steer_hit && (steer_word == ADDR_W'(i));
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                en_q[i]  <= 1'b0;
                tgt_q[i] <= '0;
            end else if (sel) begin
                en_q[i]  <= reg_wdata_i[STEER_EN_BIT];
                tgt_q[i] <= reg_wdata_i[TGT_W-1:0];
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata_o = '0;
        if (ctrl_hit) begin
            reg_rdata_o[0] = gen_q;
        end
        for (int k = 0; k < NUM_LINES; k++) begin
            if (steer_hit && (steer_word == ADDR_W'(k))) begin
                reg_rdata_o = {en_q[k], {(31-TGT_W){1'b0}}, tgt_q[k]};
            end
        end
    end

    assign gen_o       = gen_q;
    assign steer_en_o  = en_q;
    assign steer_tgt_o = tgt_q;

endmodule

// File: rtl/irq_dist_line.sv
`timescale 1ns/1ps
module irq_dist_line
    import irq_dist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TGT_W     = 2,
    parameter int LINE_W    = 8,
    parameter int LINE_IDX  = 0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          gen_i,
    input  logic                          lvl_i,
    input  logic                          steer_en_i,
    input  logic [TGT_W-1:0]              steer_tgt_i,
    input  logic [NUM_CORES-1:0]          acc_valid_i,
    input  logic [NUM_CORES*LINE_W-1:0]   acc_line_i,
    output logic [NUM_CORES-1:0]          pend_o
);

    line_state_t      st_q, st_d;
    logic [TGT_W-1:0] tgt_q;
    logic             route_ok;
    logic             acc_hit;
    logic             capture;

    // Route is valid only when enabled and the core exists
    assign route_ok = steer_en_i &&
                      ({1'b0, steer_tgt_i} < (TGT_W+1)'(NUM_CORES));

    // Accept from the latched target core naming this line
    always_comb begin
        acc_hit = 1'b0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if ((TGT_W'(c) == tgt_q) && acc_valid_i[c] &&
                (acc_line_i[c*LINE_W +: LINE_W] == LINE_W'(LINE_IDX))) begin
                acc_hit = 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        unique case (st_q)
            LN_IDLE: begin
                if (gen_i && lvl_i && route_ok) begin
                    st_d    = LN_PEND;
                    capture = 1'b1;
                end
            end
            LN_PEND: begin
                if (gen_i && acc_hit) begin
                    st_d = LN_TAKEN;
                end
            end
            LN_TAKEN: begin
                if (!lvl_i) begin
                    st_d = LN_IDLE;
                end
            end
            default: st_d = LN_IDLE;
        endcase
    end

    // State register and latched target
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= LN_IDLE;
            tgt_q <= '0;
        end else begin
            st_q <= st_d;
            if (capture) begin
                tgt_q <= steer_tgt_i;
            end
        end
    end

    // Outputs
    always_comb begin
        pend_o = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            pend_o[c] = (st_q == LN_PEND) && gen_i && (tgt_q == TGT_W'(c));
        end
    end

endmodule

// File: rtl/irq_dist_top.sv
`timescale 1ns/1ps
module irq_dist_top
    import irq_dist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 224,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    parameter int TGT_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          reg_wr_i,
    input  logic [14:0]                   reg_addr_i,
    input  logic [31:0]                   reg_wdata_i,
    output logic [31:0]                   reg_rdata_o,
    input  logic [NUM_LINES-1:0]          irq_i,
    input  logic [NUM_CORES-1:0]          acc_valid_i,
    input  logic [NUM_CORES*LINE_W-1:0]   acc_line_i,
    output logic [NUM_CORES*NUM_LINES-1:0] pend_o
);

    logic                            gen_en;
    logic [NUM_LINES-1:0]            steer_en;
    logic [NUM_LINES-1:0][TGT_W-1:0] steer_tgt;

    irq_dist_regs #(
        .NUM_LINES (NUM_LINES),
        .TGT_W     (TGT_W),
        .ADDR_W    (WIN_AW)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .gen_o       (gen_en),
        .steer_en_o  (steer_en),
        .steer_tgt_o (steer_tgt)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [NUM_CORES-1:0] lp;

        irq_dist_line #(
            .NUM_CORES (NUM_CORES),
            .TGT_W     (TGT_W),
            .LINE_W    (LINE_W),
            .LINE_IDX  (i)
        ) u_line (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .gen_i       (gen_en),
            .lvl_i       (irq_i[i]),
            .steer_en_i  (steer_en[i]),
            .steer_tgt_i (steer_tgt[i]),
            .acc_valid_i (acc_valid_i),
            .acc_line_i  (acc_line_i),
            .pend_o      (lp)
        );

        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign pend_o[c*NUM_LINES + i] = lp[c];
        end
    end

endmodule

// File: rtl/irq_dist_chk.sv
`timescale 1ns/1ps
module irq_dist_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 224,
    parameter int LINE_W    = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           gen_i,
    input  logic                           reg_wr_i,
    input  logic [14:0]                    reg_addr_i,
    input  logic                           wbit0_i,
    input  logic [NUM_CORES-1:0]           acc_valid_i,
    input  logic [NUM_CORES*LINE_W-1:0]    acc_line_i,
    input  logic [NUM_CORES*NUM_LINES-1:0] pend_i
);

    AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 15'h0) |=> (gen_i == $past(wbit0_i))); // R2

    AST_GEN_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gen_i |-> (pend_i == '0)); // R10

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
        logic [NUM_CORES-1:0] col;
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_col
            assign col[c] = pend_i[c*NUM_LINES + i];
        end

        AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $countones(col) <= 1); // R4

        for (genvar c = 0; c < NUM_CORES; c++) begin : g_pc
            logic named;
            assign named = acc_valid_i[c] &&
                           (acc_line_i[c*LINE_W +: LINE_W] == LINE_W'(i));

            AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (col[c] && !named) |=> (col[c] || !gen_i)); // R6

            AST_ACCEPT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (col[c] && named) |=> !col[c]); // R8
        end
    end

endmodule

bind irq_dist_top irq_dist_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gen_i       (gen_en),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .wbit0_i     (reg_wdata_i[0]),
    .acc_valid_i (acc_valid_i),
    .acc_line_i  (acc_line_i),
    .pend_i      (pend_o)
);

// File: tb/tb_irq_dist_top.sv
`timescale 1ns/1ps
module tb_irq_dist_top;

    localparam int NC = 3;
    localparam int NL = 6;
    localparam int LW = 3;
    localparam int PW = NC * NL;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           reg_wr;
    logic [14:0]    reg_addr;
    logic [31:0]    reg_wdata;
    logic [31:0]    reg_rdata;
    logic [NL-1:0]  irq;
    logic [NC-1:0]  acc_valid;
    logic [NC*LW-1:0] acc_line;
    logic [PW-1:0]  pend;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_dist_top #(.NUM_CORES(NC), .NUM_LINES(NL)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_i       (irq),
        .acc_valid_i (acc_valid),
        .acc_line_i  (acc_line),
        .pend_o      (pend)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic accept(input int c, input int i);
        acc_valid[c] = 1'b1;
        acc_line[c*LW +: LW] = LW'(i);
        tick();
        acc_valid = '0;
        acc_line  = '0;
    endtask

    function automatic logic [14:0] sa(input int i);
        return 15'h1000 + 15'(4 * i);
    endfunction

    function automatic logic [31:0] pb(input int c, input int i);
        return 32'(1) << (c * NL + i);
    endfunction

    function automatic logic [31:0] pv();
        return 32'(pend);
    endfunction

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq = '0; acc_valid = '0; acc_line = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 pend after reset", pv(), 32'h0);
        rd(15'h0, d); chk("R1 ctrl after reset", d, 32'h0);
        for (int i = 0; i < NL; i++) begin
            rd(sa(i), d); chk("R1 steer after reset", d, 32'h0);
        end

        // R3 steering register fields and decode
        for (int i = 0; i < NL; i++) begin
            wr(sa(i), 32'hFFFF_FFF0 | 32'(i % 3));
            rd(sa(i), d); chk("R3 steer readback", d, 32'h8000_0000 | 32'(i % 3));
        end
        wr(15'h1001, 32'h0000_0002);
        rd(15'h1000, d); chk("R3 misaligned write ignored", d, 32'h8000_0000);
        rd(15'h1001, d); chk("R3 misaligned read zero", d, 32'h0);
        wr(sa(NL), 32'h8000_0001);
        rd(sa(NL), d); chk("R3 past last line reads zero", d, 32'h0);
        wr(15'h0100, 32'hFFFF_FFFF);
        rd(15'h0100, d); chk("R3 unmapped 0x100 reads zero", d, 32'h0);
        rd(15'h0, d); chk("R3 unmapped write left ctrl", d, 32'h0);

        // R2 global enable off blocks delivery
        wr(sa(0), 32'h8000_0000);
        irq[0] = 1'b1; tick();
        chk("R2 no delivery while disabled", pv(), 32'h0);
        irq[0] = 1'b0; tick();
        wr(15'h0, 32'hFFFF_FFFF);
        rd(15'h0, d); chk("R2 ctrl readback", d, 32'h1);

        // R4/R5 sweep: every line, every target code, route on/off
        for (int i = 0; i < NL; i++) begin
            for (int t = 0; t < 4; t++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [31:0] exp;
                    wr(sa(i), (en != 0 ? 32'h8000_0000 : 32'h0) | 32'(t));
                    irq[i] = 1'b1; tick();
                    exp = (en != 0 && t < NC) ? pb(t, i) : 32'h0;
                    if (exp != 0) begin
                        chk("R4 routed to target only", pv(), exp);
                        accept(t, i);
                        chk("R8 accept clears", pv(), 32'h0);
                    end else begin
                        chk("R5 blocked route", pv(), exp);
                    end
                    irq[i] = 1'b0; tick();
                end
            end
        end

        // R6/R7 latched pending and foreign accepts
        wr(sa(2), 32'h8000_0001);
        irq[2] = 1'b1; tick();
        chk("R6 captured", pv(), pb(1, 2));
        irq[2] = 1'b0; repeat (3) tick();
        chk("R6 held after input falls", pv(), pb(1, 2));
        accept(0, 2);
        chk("R7 other core accept ignored", pv(), pb(1, 2));
        accept(1, 3);
        chk("R7 other line accept ignored", pv(), pb(1, 2));
        accept(1, 2);
        chk("R6 cleared by target accept", pv(), 32'h0);

        // R8 no re-delivery until the line falls and rises
        wr(sa(4), 32'h8000_0002);
        irq[4] = 1'b1; tick();
        chk("R8 first delivery", pv(), pb(2, 4));
        accept(2, 4);
        repeat (3) tick();
        chk("R8 held high stays quiet", pv(), 32'h0);
        irq[4] = 1'b0; tick();
        chk("R8 low stays quiet", pv(), 32'h0);
        irq[4] = 1'b1; tick();
        chk("R8 new rise delivers", pv(), pb(2, 4));
        accept(2, 4);
        irq[4] = 1'b0; tick();

        // R9 target latched at capture
        wr(sa(5), 32'h8000_0000);
        irq[5] = 1'b1; tick();
        chk("R9 captured at core 0", pv(), pb(0, 5));
        wr(sa(5), 32'h8000_0002);
        chk("R9 retarget does not move", pv(), pb(0, 5));
        accept(2, 5);
        chk("R9 new target accept ignored", pv(), pb(0, 5));
        accept(0, 5);
        chk("R9 latched target accept clears", pv(), 32'h0);
        irq[5] = 1'b0; tick();

        // R10 enable masking
        wr(sa(1), 32'h8000_0002);
        irq[1] = 1'b1; tick();
        chk("R10 captured", pv(), pb(2, 1));
        wr(15'h0, 32'h0);
        chk("R10 hidden while disabled", pv(), 32'h0);
        accept(2, 1);
        wr(15'h0, 32'h1);
        chk("R10 restored and accept ignored", pv(), pb(2, 1));
        accept(2, 1);
        chk("R10 accept after restore clears", pv(), 32'h0);
        irq[1] = 1'b0; tick();

        summary();
        $finish;
    end

endmodule